// File: doc/BRIEF.md
# Multichannel DMA Control Register and Interrupt Block

This block is the register front end for a bank of DMA channels. For every channel it holds the transfer settings: a buffer address, a line length, a line count, a line pitch, and a control word. The control word carries the channel number, a burst-mode flag and a direction flag. Writing a channel's address register is the final configuration step. That write starts the channel with a one-cycle start pulse.

The block sends each channel's parameter fields to the address generators, which sit outside this block, and receives their completion pulses. Completions set bits in a shared status register. Software clears those bits by writing ones. An enable mask picks which status bits drive the single interrupt output.

A termination register turns written ones into one-cycle stop pulses. A loop register enables looped operation for a channel only when both of that channel's paired bits are set.

Top module: `dma_csr_top`

## Requirements
- R1: After reset every register reads zero, and all start, stop, loop and parameter outputs are zero. irq_o is low.
- R2: Each channel c has a 16-byte window at byte offset c*0x10. The address register sits at +0x0 and stores 32 bits. The line length at +0x4 and the line count at +0x8 store LEN_W bits each. Upper bits of those two read as zero. Every stored value appears on the matching channel output.
- R3: The control register sits at +0xC. Bits [3:0] hold the channel number, bit 4 is the burst flag and bit 5 is the direction flag. Bits 4 and 5 drive ch_burst_o[c] and ch_dir_o[c]. Bits above 5 read as zero.
- R4: The pitch register of channel c sits at 0x100 + 4*c. It stores LEN_W bits and drives ch_pitch_o.
- R5: A write to channel c's address register raises ch_start_o[c] for exactly the one cycle after the write edge. Writes to the channel's other registers raise no start.
- R6: The status register at 0x144 has bit c set by a ch_done_i[c] pulse. Writing 1 to a bit clears it, and bits written 0 keep their value.
- R7: When a done pulse and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R8: The enable register at 0x148 holds one bit per channel. irq_o is the OR over channels of status AND enable, so it goes high in the cycle after an enabled done pulse.
- R9: Writing 1s to the termination register at 0x140 raises ch_stop_o on those bits for exactly one cycle. This register reads zero and leaves status and enable unchanged.
- R10: The loop register at 0x150 reads back bits c and c+16 for each channel. ch_loop_o[c] is high only while both of those bits are set.
- R11: Unmapped offsets, such as 0x14C and 0x200, read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from bus_addr_i |
| ch_addr_o | output | NUM_CH*32 | Buffer address for each channel |
| ch_xlen_o | output | NUM_CH*LEN_W | Line length for each channel |
| ch_ylen_o | output | NUM_CH*LEN_W | Line count for each channel |
| ch_pitch_o | output | NUM_CH*LEN_W | Line pitch for each channel |
| ch_burst_o | output | NUM_CH | Burst-mode flag for each channel |
| ch_dir_o | output | NUM_CH | Direction flag for each channel |
| ch_start_o | output | NUM_CH | One-cycle start pulse for each channel |
| ch_stop_o | output | NUM_CH | One-cycle stop pulse for each channel |
| ch_loop_o | output | NUM_CH | Loop enable for each channel |
| ch_done_i | input | NUM_CH | Completion pulses from the channels |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that the bus and the done pulses are synchronous to clk_i and hold known values from the first edge after reset. They also assume that a status bit changes only through a done pulse or a clear write, and never through any other path. The bench drives every input on the falling edge, with word-aligned addresses, and keeps done pulses to one cycle. It checks results on a later falling edge, so each register update and each pulse is seen after exactly one rising edge.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  // word index inside a channel window
  localparam logic [1:0] WIN_ADDR = 2'd0;
  localparam logic [1:0] WIN_XLEN = 2'd1;
  localparam logic [1:0] WIN_YLEN = 2'd2;
  localparam logic [1:0] WIN_CTRL = 2'd3;

  localparam int PITCH_BASE = 'h100;
  localparam int TERM_OFF   = 'h140;
  localparam int STAT_OFF   = 'h144;
  localparam int EN_OFF     = 'h148;
  localparam int LOOP_OFF   = 'h150;

  localparam int LOOP_HI    = 16;
  localparam int CTRL_W     = 6;
  localparam int BURST_BIT  = 4;
  localparam int DIR_BIT    = 5;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_csr_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_addr_i,
  input  logic              wr_xlen_i,
  input  logic              wr_ylen_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_pitch_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       addr_o,
  output logic [LEN_W-1:0]  xlen_o,
  output logic [LEN_W-1:0]  ylen_o,
  output logic [LEN_W-1:0]  pitch_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      xlen_o  <= '0;
      ylen_o  <= '0;
      pitch_o <= '0;
      ctrl_o  <= '0;
      start_o <= 1'b0;
    end else begin
      if (wr_addr_i)  addr_o  <= wdata_i;
      if (wr_xlen_i)  xlen_o  <= wdata_i[LEN_W-1:0];
      if (wr_ylen_i)  ylen_o  <= wdata_i[LEN_W-1:0];
      if (wr_pitch_i) pitch_o <= wdata_i[LEN_W-1:0];
      if (wr_ctrl_i)  ctrl_o  <= wdata_i[CTRL_W-1:0];
      // address write is the launch step
      start_o <= wr_addr_i;
    end
  end

  p_start_on_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_addr_i |=> start_o);
  p_no_start_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_addr_i |=> !start_o);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] done_i,
  input  logic              clr_we_i,
  input  logic              en_we_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] status_o,
  output logic [NUM_CH-1:0] enable_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] clr_mask;
  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      enable_o <= '0;
    end else begin
      // set wins over a same-cycle clear
      status_o <= (status_o & ~clr_mask) | done_i;
      if (en_we_i) enable_o <= wdata_i;
    end
  end

  assign irq_o = |(status_o & enable_o);

  p_done_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_i) |=> ((status_o & $past(done_i)) == $past(done_i)));
  p_hold_no_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic                    bus_we_i,
  input  logic [31:0]             bus_wdata_i,
  output logic [31:0]             bus_rdata_o,
  output logic [NUM_CH*32-1:0]    ch_addr_o,
  output logic [NUM_CH*LEN_W-1:0] ch_xlen_o,
  output logic [NUM_CH*LEN_W-1:0] ch_ylen_o,
  output logic [NUM_CH*LEN_W-1:0] ch_pitch_o,
  output logic [NUM_CH-1:0]       ch_burst_o,
  output logic [NUM_CH-1:0]       ch_dir_o,
  output logic [NUM_CH-1:0]       ch_start_o,
  output logic [NUM_CH-1:0]       ch_stop_o,
  output logic [NUM_CH-1:0]       ch_loop_o,
  input  logic [NUM_CH-1:0]       ch_done_i,
  output logic                    irq_o
);
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [ADDR_W-1:0] WIN_END   = ADDR_W'(NUM_CH * 16);
  localparam logic [ADDR_W-1:0] PITCH_LO  = ADDR_W'(PITCH_BASE);
  localparam logic [ADDR_W-1:0] PITCH_END = ADDR_W'(PITCH_BASE + 4 * NUM_CH);

  // address decode
  logic          aligned, in_win, in_pitch;
  logic          hit_term, hit_stat, hit_en, hit_loop;
  logic [CW-1:0] win_ch, pitch_ch;
  logic [1:0]    win_reg;

  assign aligned  = (bus_addr_i[1:0] == 2'b00);
  assign in_win   = aligned && (bus_addr_i < WIN_END);
  assign in_pitch = aligned && (bus_addr_i >= PITCH_LO) && (bus_addr_i < PITCH_END);
  assign win_ch   = bus_addr_i[4 +: CW];
  assign win_reg  = bus_addr_i[3:2];
  assign pitch_ch = bus_addr_i[2 +: CW];
  assign hit_term = (bus_addr_i == ADDR_W'(TERM_OFF));
  assign hit_stat = (bus_addr_i == ADDR_W'(STAT_OFF));
  assign hit_en   = (bus_addr_i == ADDR_W'(EN_OFF));
  assign hit_loop = (bus_addr_i == ADDR_W'(LOOP_OFF));

  // per-channel parameter storage
  logic [31:0]       addr_a  [NUM_CH];
  logic [LEN_W-1:0]  xlen_a  [NUM_CH];
  logic [LEN_W-1:0]  ylen_a  [NUM_CH];
  logic [LEN_W-1:0]  pitch_a [NUM_CH];
  logic [CTRL_W-1:0] ctrl_a  [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wsel, psel;
    assign wsel = bus_we_i && in_win && (win_ch == CW'(c));
    assign psel = bus_we_i && in_pitch && (pitch_ch == CW'(c));

    dma_chan_regs #(.LEN_W(LEN_W)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_addr_i  (wsel && (win_reg == WIN_ADDR)),
      .wr_xlen_i  (wsel && (win_reg == WIN_XLEN)),
      .wr_ylen_i  (wsel && (win_reg == WIN_YLEN)),
      .wr_ctrl_i  (wsel && (win_reg == WIN_CTRL)),
      .wr_pitch_i (psel),
      .wdata_i    (bus_wdata_i),
      .addr_o     (addr_a[c]),
      .xlen_o     (xlen_a[c]),
      .ylen_o     (ylen_a[c]),
      .pitch_o    (pitch_a[c]),
      .ctrl_o     (ctrl_a[c]),
      .start_o    (ch_start_o[c])
    );

    assign ch_addr_o [c*32 +: 32]       = addr_a[c];
    assign ch_xlen_o [c*LEN_W +: LEN_W] = xlen_a[c];
    assign ch_ylen_o [c*LEN_W +: LEN_W] = ylen_a[c];
    assign ch_pitch_o[c*LEN_W +: LEN_W] = pitch_a[c];
    assign ch_burst_o[c] = ctrl_a[c][BURST_BIT];
    assign ch_dir_o[c]   = ctrl_a[c][DIR_BIT];
  end

  // interrupt status and enable
  logic [NUM_CH-1:0] status, enable;

  dma_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (ch_done_i),
    .clr_we_i (bus_we_i && hit_stat),
    .en_we_i  (bus_we_i && hit_en),
    .wdata_i  (bus_wdata_i[NUM_CH-1:0]),
    .status_o (status),
    .enable_o (enable),
    .irq_o    (irq_o)
  );

  // loop pairs and termination pulses
  logic [NUM_CH-1:0] loop_lo, loop_hi, stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loop_lo <= '0;
      loop_hi <= '0;
      stop_q  <= '0;
    end else begin
      if (bus_we_i && hit_loop) begin
        loop_lo <= bus_wdata_i[NUM_CH-1:0];
        loop_hi <= bus_wdata_i[LOOP_HI +: NUM_CH];
      end
      stop_q <= (bus_we_i && hit_term) ? bus_wdata_i[NUM_CH-1:0] : '0;
    end
  end

  assign ch_loop_o = loop_lo & loop_hi;
  assign ch_stop_o = stop_q;

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (in_win) begin
      unique case (win_reg)
        WIN_ADDR: bus_rdata_o = addr_a[win_ch];
        WIN_XLEN: bus_rdata_o = 32'(xlen_a[win_ch]);
        WIN_YLEN: bus_rdata_o = 32'(ylen_a[win_ch]);
        default:  bus_rdata_o = 32'(ctrl_a[win_ch]);
      endcase
    end else if (in_pitch) begin
      bus_rdata_o = 32'(pitch_a[pitch_ch]);
    end else if (hit_stat) begin
      bus_rdata_o = 32'(status);
    end else if (hit_en) begin
      bus_rdata_o = 32'(enable);
    end else if (hit_loop) begin
      bus_rdata_o[NUM_CH-1:0]         = loop_lo;
      bus_rdata_o[LOOP_HI +: NUM_CH]  = loop_hi;
    end
  end

  p_stop_needs_term_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && hit_term) |=> (ch_stop_o == '0));
  p_loop_pair_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && hit_loop) |=> $stable(ch_loop_o));
endmodule

// File: tb/sim_dma_csr_top.sv
module sim_dma_csr_top;
  localparam int NUM_CH = 16;
  localparam int LEN_W  = 16;
  localparam int ADDR_W = 12;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [ADDR_W-1:0]       addr = '0;
  logic                    we = 1'b0;
  logic [31:0]             wdata = '0;
  logic [31:0]             rdata;
  logic [NUM_CH*32-1:0]    ch_addr;
  logic [NUM_CH*LEN_W-1:0] ch_xlen, ch_ylen, ch_pitch;
  logic [NUM_CH-1:0]       ch_burst, ch_dir, ch_start, ch_stop, ch_loop;
  logic [NUM_CH-1:0]       done = '0;
  logic                    irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_csr_top #(.NUM_CH(NUM_CH), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ch_addr_o(ch_addr),
    .ch_xlen_o(ch_xlen), .ch_ylen_o(ch_ylen), .ch_pitch_o(ch_pitch),
    .ch_burst_o(ch_burst), .ch_dir_o(ch_dir), .ch_start_o(ch_start),
    .ch_stop_o(ch_stop), .ch_loop_o(ch_loop), .ch_done_i(done), .irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse_done(input logic [NUM_CH-1:0] m);
    @(negedge clk);
    done = m;
    @(negedge clk);
    done = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h144, d); chk(d, 0, "R1 status");
    rd(12'h008, d); chk(d, 0, "R1 ylen");
    rd(12'h150, d); chk(d, 0, "R1 loop");
    chk(32'(irq), 0, "R1 irq");
    chk(32'(ch_start | ch_stop | ch_loop), 0, "R1 pulses");
    chk(ch_addr[31:0], 0, "R1 addr out");
  endtask

  task automatic t_params;
    logic [31:0] d;
    wr(12'h020, 32'h1234_5678);
    rd(12'h020, d); chk(d, 32'h1234_5678, "R2 addr ch2");
    chk(ch_addr[2*32 +: 32], 32'h1234_5678, "R2 addr out ch2");
    wr(12'h014, 32'hABCD_1234);
    rd(12'h014, d); chk(d, 32'h0000_1234, "R2 xlen ch1 upper zero");
    chk(32'(ch_xlen[1*LEN_W +: LEN_W]), 32'h1234, "R2 xlen out");
    wr(12'h018, 32'h0000_00FF);
    rd(12'h018, d); chk(d, 32'hFF, "R2 ylen ch1");
    chk(32'(ch_ylen[1*LEN_W +: LEN_W]), 32'hFF, "R2 ylen out");
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    wr(12'h0FC, 32'hFFFF_FFFF);
    rd(12'h0FC, d); chk(d, 32'h3F, "R3 ctrl ch15 mask");
    chk(32'({ch_burst[15], ch_dir[15]}), 32'h3, "R3 burst/dir ch15");
    wr(12'h00C, 32'h0000_0020);
    chk(32'({ch_burst[0], ch_dir[0]}), 32'h1, "R3 dir only ch0");
  endtask

  task automatic t_pitch;
    logic [31:0] d;
    wr(12'h114, 32'h0007_0010);
    rd(12'h114, d); chk(d, 32'h10, "R4 pitch ch5");
    chk(32'(ch_pitch[5*LEN_W +: LEN_W]), 32'h10, "R4 pitch out");
  endtask

  task automatic t_start;
    wr(12'h070, 32'h8000_0000);
    chk(32'(ch_start), 32'h80, "R5 start ch7");
    @(negedge clk);
    chk(32'(ch_start), 0, "R5 start one cycle");
    wr(12'h074, 32'h5);
    chk(32'(ch_start), 0, "R5 no start on xlen");
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(12'h148, 32'h0000_0208);
    pulse_done(16'h0008);
    rd(12'h144, d); chk(d, 32'h8, "R6 set ch3");
    chk(32'(irq), 1, "R8 irq enabled ch3");
    pulse_done(16'h0010);
    rd(12'h144, d); chk(d, 32'h18, "R6 set ch4");
    wr(12'h144, 32'h8);
    rd(12'h144, d); chk(d, 32'h10, "R6 w1c ch3");
    chk(32'(irq), 0, "R8 masked ch4");
    wr(12'h144, 32'h0);
    rd(12'h144, d); chk(d, 32'h10, "R6 write0 keeps");
    // R7: set and clear in the same cycle
    @(negedge clk);
    addr = 12'h144; wdata = 32'h0000_0010; we = 1'b1; done = 16'h0010;
    @(negedge clk);
    we = 1'b0; done = '0;
    rd(12'h144, d); chk(d, 32'h10, "R7 set beats clear");
  endtask

  task automatic t_term;
    logic [31:0] d;
    wr(12'h140, 32'h0000_0005);
    chk(32'(ch_stop), 32'h5, "R9 stop pulse");
    @(negedge clk);
    chk(32'(ch_stop), 0, "R9 stop one cycle");
    rd(12'h140, d); chk(d, 0, "R9 reads zero");
    rd(12'h144, d); chk(d, 32'h10, "R9 status untouched");
    rd(12'h148, d); chk(d, 32'h208, "R9 enable untouched");
  endtask

  task automatic t_loop;
    logic [31:0] d;
    wr(12'h150, 32'h0001_0003);
    chk(32'(ch_loop), 32'h1, "R10 loop needs pair");
    rd(12'h150, d); chk(d, 32'h0001_0003, "R10 readback");
    wr(12'h150, 32'h0);
    chk(32'(ch_loop), 0, "R10 loop cleared");
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(12'h14C, d); chk(d, 0, "R11 read 0x14C");
    rd(12'h200, d); chk(d, 0, "R11 read 0x200");
    wr(12'h14C, 32'hFFFF_FFFF);
    rd(12'h148, d); chk(d, 32'h208, "R11 write ignored enable");
    rd(12'h144, d); chk(d, 32'h10, "R11 write ignored status");
  endtask

  initial begin
    #20;
    @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_params;
    t_ctrl;
    t_pitch;
    t_start;
    t_irq;
    t_term;
    t_loop;
    t_unmapped;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule